// File: doc/BRIEF.md
# DMA Interrupt Flag Collector and Priority Index

This block gathers the interrupt sources of a multi-channel DMA engine into one set of flags and turns them into a single interrupt line and a priority index. Each channel can raise a completion event. The lower-numbered channels can also raise an early-warning event a few transfers before they finish. Two engine-wide error events, one for addresses and one for data, complete the set. Each event is a one-cycle pulse that sets a sticky raw flag. A per-source enable mask gates the flags into an enabled status. The interrupt line stays high while any enabled flag is set.

Software works through a small write port. One write carries an opcode and a bit vector, so it can change several sources at once: it can enable them, disable them, or clear their raw flags. The index output always names the highest-priority enabled pending source. The index encoding places every completion source ahead of every early-warning source. A service routine that reads an early-warning index can therefore be sure that the same channel's completion is not yet pending, or at least not enabled. Pulsing the take input acts as a read of the index and clears the raw flag of the source it names.

All ports are plain control and status signals. The block has no data stream, so it has no valid/ready handshake and no back-pressure. The index is a level that is valid in every cycle, and the take input is a one-cycle strobe that needs no acknowledgement.

Top module: `dma_irq_index`

## Requirements
- R1: After reset, all raw flags and all mask bits are 0, `irq_idx` is 0 and `irq` is low.
- R2: A high event input at a clock edge sets its raw flag, whatever the mask holds. Bit positions in every status vector and in `cfg_bits` are as follows: bits 0 to N_DONE-1 are channel completion, the next N_EARLY bits are early warning, then address error, then data error (bits 0..25 with the defaults).
- R3: A raw flag stays set until a flag-clear write or a take removes it.
- R4: A write with `cfg_op` = 0 sets the mask bits that are 1 in `cfg_bits`, and `cfg_op` = 1 clears them. Every other mask bit keeps its value.
- R5: A write with `cfg_op` = 2 clears the raw flags that are 1 in `cfg_bits`. A write with `cfg_op` = 3 changes neither flags nor mask.
- R6: `enabled_status` equals raw AND mask, and `irq` is high exactly when `enabled_status` is nonzero.
- R7: `irq_idx` is 0 when no enabled flag is set. Otherwise it is k+1 for the lowest set bit k of `enabled_status`: completion of channel c gives c+1, early warning of channel e gives N_DONE+1+e, address error gives N_DONE+N_EARLY+1 and data error gives N_DONE+N_EARLY+2.
- R8: Any enabled completion flag outranks any enabled early-warning flag, whatever the channel numbers.
- R9: `idx_take` high at an edge clears only the raw flag named by `irq_idx` in that cycle. The early-warning flag of the same channel, like all other flags, stays set.
- R10: `idx_take` while `irq_idx` is 0 changes no flag.
- R11: If an event sets a flag in the same cycle that a flag-clear write or a take clears it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| done_evt | input | N_DONE | Per-channel completion pulses |
| early_evt | input | N_EARLY | Per-channel early-warning pulses |
| addr_err_evt | input | 1 | Address error pulse |
| data_err_evt | input | 1 | Data error pulse |
| cfg_we | input | 1 | Write strobe for the register port |
| cfg_op | input | 2 | 0 mask set, 1 mask clear, 2 flag clear, 3 no operation |
| cfg_bits | input | N_DONE+N_EARLY+2 | Source select vector for the write |
| idx_take | input | 1 | Index read strobe; clears the reported source |
| irq_idx | output | $clog2(N_DONE+N_EARLY+3) | Highest-priority enabled pending source, 0 if none |
| raw_status | output | N_DONE+N_EARLY+2 | Raw flags |
| mask_status | output | N_DONE+N_EARLY+2 | Enable mask |
| enabled_status | output | N_DONE+N_EARLY+2 | Raw flags ANDed with mask |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default sizes, 16 completion channels and 8 early-warning channels. This makes all 27 index codes reachable, including the two error codes at the top of the range and the boundary between the last completion code (16) and the first early-warning code (17). With these sizes, directed cases can put a high-numbered completion against a low-numbered early warning. A long run of sparse random events, writes and takes then drives set-versus-clear collisions on the same bit and takes of an idle index.

// File: rtl/dma_irqx_pkg.sv
package dma_irqx_pkg;

  typedef enum logic [1:0] {
    OP_MASK_SET = 2'd0,
    OP_MASK_CLR = 2'd1,
    OP_FLAG_CLR = 2'd2,
    OP_NONE     = 2'd3
  } irq_op_e;

endpackage

// File: rtl/irqx_flag_bank.sv
module irqx_flag_bank #(
  parameter int W = 26
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);

  // One sticky flop per source; a set in the same cycle beats any clear.
  for (genvar k = 0; k < W; k++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_o[k] <= 1'b0;
      else if (set_i[k])   flag_o[k] <= 1'b1;
      else if (clr_i[k])   flag_o[k] <= 1'b0;
    end
  end

  // R2 / R11: every bit pulsed at an edge reads as set afterwards
  p_set_sticks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flag_o & $past(set_i)) == $past(set_i)));

  // R5 / R9: cleared bits without a simultaneous set read as zero
  p_clear_takes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((flag_o & $past(clr_i & ~set_i)) == '0));

  // R3: with no set or clear, the flags hold
  p_flags_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i == '0) && (clr_i == '0)) |=> $stable(flag_o));

endmodule

// File: rtl/irqx_mask_reg.sv
module irqx_mask_reg
  import dma_irqx_pkg::*;
#(
  parameter int W = 26
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  irq_op_e      op_i,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] mask_o
);

  logic [W-1:0] mask_nxt;

  always_comb begin
    mask_nxt = mask_o;
    if (we_i) begin
      case (op_i)
        OP_MASK_SET: mask_nxt = mask_o | bits_i;
        OP_MASK_CLR: mask_nxt = mask_o & ~bits_i;
        default:     mask_nxt = mask_o;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_o <= '0;
    else        mask_o <= mask_nxt;
  end

  // R4: a set-mask write enables every selected source
  p_mask_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && op_i == OP_MASK_SET) |=> ((mask_o & $past(bits_i)) == $past(bits_i)));

  // R4: a clear-mask write disables every selected source
  p_mask_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && op_i == OP_MASK_CLR) |=> ((mask_o & $past(bits_i)) == '0));

  // R5: flag-clear and no-op writes leave the mask alone
  p_mask_untouched_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_i || op_i == OP_FLAG_CLR || op_i == OP_NONE) |=> $stable(mask_o));

endmodule

// File: rtl/irqx_prio_enc.sv
module irqx_prio_enc #(
  parameter int W  = 26,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  req_i,
  output logic [IW-1:0] idx_o
);

  // Lowest set bit wins; code is bit position plus one, zero for idle.
  always_comb begin
    idx_o = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (req_i[k]) idx_o = IW'(k + 1);
    end
  end

  // Checker-side view: requests strictly below the reported position.
  logic [W-1:0] below_mask;
  always_comb begin
    below_mask = '0;
    for (int k = 0; k < W; k++) begin
      if (IW'(k + 1) < idx_o) below_mask[k] = 1'b1;
    end
  end

  // R7: a nonzero code names a live request
  p_idx_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_o != '0) |-> req_i[idx_o - IW'(1)]);

  // R7 / R8: nothing of higher priority is skipped
  p_idx_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_o != '0) |-> ((req_i & below_mask) == '0));

  // R7: idle code only when nothing is requested
  p_idx_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_o == '0) |-> (req_i == '0));

endmodule

// File: rtl/dma_irq_index.sv
module dma_irq_index
  import dma_irqx_pkg::*;
#(
  parameter  int N_DONE  = 16,
  parameter  int N_EARLY = 8,
  localparam int NSRC    = N_DONE + N_EARLY + 2,
  localparam int IDX_W   = $clog2(NSRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_DONE-1:0]  done_evt,
  input  logic [N_EARLY-1:0] early_evt,
  input  logic               addr_err_evt,
  input  logic               data_err_evt,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_op,
  input  logic [NSRC-1:0]    cfg_bits,
  input  logic               idx_take,
  output logic [IDX_W-1:0]   irq_idx,
  output logic [NSRC-1:0]    raw_status,
  output logic [NSRC-1:0]    mask_status,
  output logic [NSRC-1:0]    enabled_status,
  output logic               irq
);

  irq_op_e      op;
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] wr_clr;
  logic [NSRC-1:0] take_clr;
  logic [NSRC-1:0] clr_vec;

  assign op      = irq_op_e'(cfg_op);
  assign set_vec = {data_err_evt, addr_err_evt, early_evt, done_evt};
  assign wr_clr  = (cfg_we && op == OP_FLAG_CLR) ? cfg_bits : '0;

  // Decode the reported code back to its source bit for read-to-clear.
  for (genvar k = 0; k < NSRC; k++) begin : g_take
    assign take_clr[k] = idx_take && (irq_idx == IDX_W'(k + 1));
  end

  assign clr_vec = wr_clr | take_clr;

  irqx_flag_bank #(.W(NSRC)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .flag_o (raw_status)
  );

  irqx_mask_reg #(.W(NSRC)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (cfg_we),
    .op_i   (op),
    .bits_i (cfg_bits),
    .mask_o (mask_status)
  );

  assign enabled_status = raw_status & mask_status;
  assign irq            = |enabled_status;

  irqx_prio_enc #(.W(NSRC), .IW(IDX_W)) u_enc (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (enabled_status),
    .idx_o (irq_idx)
  );

  // R9: a take clears at most one source
  p_take_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_clr));

  // R10: a take with idle index clears nothing
  p_take_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_take && irq_idx == '0) |-> (take_clr == '0));

  // R6: the encoder and the interrupt line agree
  p_idx_means_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_idx != '0) == irq);

endmodule

// File: tb/dma_irq_index_bench.sv
module dma_irq_index_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ND   = 16;
  localparam int NE   = 8;
  localparam int NS   = ND + NE + 2;
  localparam int IW   = $clog2(NS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ND-1:0] done_evt = '0;
  logic [NE-1:0] early_evt = '0;
  logic addr_err_evt = 1'b0;
  logic data_err_evt = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_op = 2'd3;
  logic [NS-1:0] cfg_bits = '0;
  logic idx_take = 1'b0;
  logic [IW-1:0] irq_idx;
  logic [NS-1:0] raw_status, mask_status, enabled_status;
  logic irq;

  dma_irq_index #(.N_DONE(ND), .N_EARLY(NE)) u_dma_irq_index (
    .clk(clk), .rst_n(rst_n), .done_evt(done_evt), .early_evt(early_evt),
    .addr_err_evt(addr_err_evt), .data_err_evt(data_err_evt),
    .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_bits(cfg_bits), .idx_take(idx_take),
    .irq_idx(irq_idx), .raw_status(raw_status), .mask_status(mask_status),
    .enabled_status(enabled_status), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  bit m_raw[NS];
  bit m_mask[NS];

  task automatic chk(string tag, string what, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic longint pack(bit v[NS]);
    longint r = 0;
    for (int k = 0; k < NS; k++) if (v[k]) r = r | (longint'(1) << k);
    return r;
  endfunction

  function automatic int model_idx();
    for (int k = 0; k < NS; k++) if (m_raw[k] && m_mask[k]) return k + 1;
    return 0;
  endfunction

  function automatic bit model_src(int k);
    if (k < ND) return done_evt[k];
    if (k < ND + NE) return early_evt[k - ND];
    if (k == ND + NE) return addr_err_evt;
    return data_err_evt;
  endfunction

  // Compare every output against the reference model.
  task automatic compare_all();
    bit en[NS];
    bit any = 0;
    for (int k = 0; k < NS; k++) begin
      en[k] = m_raw[k] & m_mask[k];
      any |= en[k];
    end
    chk("R2", "raw", longint'(raw_status), pack(m_raw));
    chk("R4", "mask", longint'(mask_status), pack(m_mask));
    chk("R6", "enabled", longint'(enabled_status), pack(en));
    chk("R6", "irq", longint'(irq), longint'(any));
    chk("R7", "idx", longint'(irq_idx), longint'(model_idx()));
  endtask

  // Advance one clock with the currently driven inputs, then idle them.
  task automatic cycle();
    int cur = model_idx();
    bit nr[NS];
    bit nm[NS];
    for (int k = 0; k < NS; k++) begin
      bit clr = 0;
      nm[k] = m_mask[k];
      if (cfg_we && cfg_op == 2'd0 && cfg_bits[k]) nm[k] = 1;
      if (cfg_we && cfg_op == 2'd1 && cfg_bits[k]) nm[k] = 0;
      if (cfg_we && cfg_op == 2'd2 && cfg_bits[k]) clr = 1;
      if (idx_take && cur == k + 1) clr = 1;
      nr[k] = model_src(k) ? 1'b1 : (clr ? 1'b0 : m_raw[k]);
    end
    @(negedge clk);
    m_raw = nr;
    m_mask = nm;
    compare_all();
    done_evt = '0; early_evt = '0; addr_err_evt = 0; data_err_evt = 0;
    cfg_we = 0; cfg_op = 2'd3; cfg_bits = '0; idx_take = 0;
  endtask

  task automatic wr(logic [1:0] op, logic [NS-1:0] bits);
    cfg_we = 1; cfg_op = op; cfg_bits = bits;
    cycle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [NS-1:0] snap;
    for (int k = 0; k < NS; k++) begin m_raw[k] = 0; m_mask[k] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "raw", longint'(raw_status), 0);
    chk("R1", "mask", longint'(mask_status), 0);
    chk("R1", "idx", longint'(irq_idx), 0);
    chk("R1", "irq", longint'(irq), 0);
    rst_n = 1;
    @(negedge clk);

    // R2: flag sets while masked; R6 no irq
    addr_err_evt = 1; cycle();
    chk("R2", "addr flag bit 24", longint'(raw_status[ND+NE]), 1);
    chk("R6", "masked irq low", longint'(irq), 0);
    chk("R7", "masked idx", longint'(irq_idx), 0);
    // R3: flag holds
    cycle();
    chk("R3", "addr flag held", longint'(raw_status[ND+NE]), 1);
    // R4: enable everything
    wr(2'd0, '1);
    chk("R4", "mask all", longint'(mask_status), (longint'(1) << NS) - 1);
    chk("R7", "addr idx", longint'(irq_idx), ND + NE + 1);
    // R5: flag clear
    wr(2'd2, NS'(1) << (ND + NE));
    chk("R5", "addr cleared", longint'(raw_status), 0);

    // R8: completion 15 against early 3
    done_evt[15] = 1; early_evt[3] = 1; cycle();
    chk("R8", "done15 beats early3", longint'(irq_idx), 16);
    // R9: take clears completion only, early of same kind stays
    idx_take = 1; cycle();
    chk("R9", "early3 idx", longint'(irq_idx), ND + 1 + 3);
    chk("R9", "early3 flag stays", longint'(raw_status[ND+3]), 1);
    done_evt[3] = 1; cycle();
    chk("R8", "done3 beats early3", longint'(irq_idx), 4);
    idx_take = 1; cycle();
    chk("R9", "early3 survives done3 take", longint'(raw_status[ND+3]), 1);
    idx_take = 1; cycle();
    chk("R9", "all taken", longint'(raw_status), 0);
    // R10: take with nothing pending
    idx_take = 1; cycle();
    chk("R10", "idle take idx", longint'(irq_idx), 0);
    chk("R10", "idle take raw", longint'(raw_status), 0);
    // R10: take with only masked flags pending
    wr(2'd1, NS'(1) << 0);
    done_evt[0] = 1; cycle();
    idx_take = 1; cycle();
    chk("R10", "masked flag survives take", longint'(raw_status[0]), 1);
    wr(2'd0, NS'(1) << 0);
    chk("R7", "done0 idx", longint'(irq_idx), 1);
    wr(2'd2, NS'(1) << 0);

    // R11: set beats flag-clear write on same bit
    data_err_evt = 1; cfg_we = 1; cfg_op = 2'd2; cfg_bits = NS'(1) << (NS - 1); cycle();
    chk("R11", "data flag set wins", longint'(raw_status[NS-1]), 1);
    chk("R7", "data idx", longint'(irq_idx), ND + NE + 2);
    // R11: set beats take on same bit
    data_err_evt = 1; idx_take = 1; cycle();
    chk("R11", "data set beats take", longint'(raw_status[NS-1]), 1);
    // R5: no-op write changes nothing
    snap = raw_status;
    wr(2'd3, '1);
    chk("R5", "noop raw", longint'(raw_status), longint'(snap));
    chk("R5", "noop mask", longint'(mask_status), (longint'(1) << NS) - 1);
    wr(2'd2, '1);

    // Random phase, model compared every clock
    for (int i = 0; i < 4000; i++) begin
      for (int k = 0; k < ND; k++) done_evt[k] = ($urandom % 24) == 0;
      for (int k = 0; k < NE; k++) early_evt[k] = ($urandom % 24) == 0;
      addr_err_evt = ($urandom % 40) == 0;
      data_err_evt = ($urandom % 40) == 0;
      if (($urandom % 4) == 0) begin
        cfg_we = 1; cfg_op = 2'($urandom);
        cfg_bits = NS'({$urandom, $urandom});
      end
      idx_take = ($urandom % 3) == 0;
      cycle();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule